// File: doc/BRIEF.md
# Single-Wire Serial Memory Host Sequencer

This block is the host side of a serial memory attached through one open-drain data line. A single request moves the whole memory, read or write. The block first sends a burst of write-zero slots. The burst parks the device's address pointer in its locked top position and leaves the stored contents untouched. The block then sends an eight-bit command word and finishes with one data slot per memory bit, least significant bit first. The line is only ever pulled low through `line_oe`, and its level comes back on `line_in`.

The caller raises `start` for one cycle with `op_write` and the write vector. During a write, each slot encodes one bit by the length of its low pulse. During a read, each slot is a short low pulse: the host releases the line and then samples it, and a device holding the line low returns a 0. `done` pulses once at the end of the transaction. A read leaves the captured vector on `rd_data` until the next read. All slot phases are parameters counted in clock cycles, with defaults derived from the number of cycles per microsecond.

Top module: `swmem_host`

## Requirements
- R1: After reset `busy`, `done` and `line_oe` are 0 and `rd_data` is all zeros. `line_oe` stays 0 whenever `busy` is 0.
- R2: Each accepted request produces exactly DATA_BITS+8 preamble slots, 8 command slots and DATA_BITS data slots: 528 low pulses at the defaults.
- R3: Every preamble slot is a write-zero slot, with `line_oe` high for T_LOW0 cycles.
- R4: The command goes out LSB first as 1, then the two select bits (0, 0), then five bits that are all 1 for a write and all 0 for a read. A 1 is sent as a write-one slot and a 0 as a write-zero slot.
- R5: A write-one slot holds `line_oe` for T_LOW1 cycles and a write-zero slot for T_LOW0 cycles. Consecutive slot falling edges are exactly T_SLOT+T_REC cycles apart, and no low pulse is longer than T_LOW0.
- R6: In a write, data slot k carries `wr_data[k]`, with k = 0 sent first.
- R7: In a read, each data slot holds `line_oe` for T_LOW1 cycles. `line_in` is sampled T_SAMPLE cycles after the line falls, and that level is stored as `rd_data[k]` for slot k. `rd_data` changes only during a read.
- R8: `done` is high for exactly one cycle after the last data slot, and `busy` is 0 in the following cycle.
- R9: A `start` that arrives while `busy` is 1 is ignored. The running transaction keeps the op and the data captured at acceptance, and no extra slots follow it.
- R10: `busy` is 1 in the cycle after a `start` that was accepted while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle transaction request |
| op_write | input | 1 | 1 = write transaction, 0 = read transaction |
| wr_data | input | DATA_BITS | Vector to write, bit 0 sent first |
| line_in | input | 1 | Level of the shared data line |
| line_oe | output | 1 | 1 = pull the data line low |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_data | output | DATA_BITS | Vector captured by the last read |

## Verification
The bench keeps DATA_BITS at 256 but shrinks every slot phase to a few cycles: T_LOW1=2, T_LOW0=8, T_SLOT=10, T_REC=2 and T_SAMPLE=4, so one slot takes 12 cycles. At these values a complete 528-slot transaction takes about 6,300 cycles, so more than a dozen full transactions fit in one run. Together they cover the preamble lock of a behavioural device, both command encodings, write-then-readback of every data bit and a start request injected mid-transfer. The sample point sits between the short host pulse and the end of the device's hold, so a missed or shifted sample shows up as corrupted read data.

// File: rtl/swmem_pkg.sv
package swmem_pkg;

  localparam int unsigned CMD_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_CMD,
    ST_DATA,
    ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    SLOT_W0,
    SLOT_W1,
    SLOT_RD
  } slot_kind_t;

  // Command word bit k (LSB first): marker, two select bits, five op bits.
  function automatic logic cmd_bit(input logic [2:0] k, input logic is_wr,
                                   input logic [1:0] sel);
    logic b;
    case (k)
      3'd0:    b = 1'b1;
      3'd1:    b = sel[0];
      3'd2:    b = sel[1];
      default: b = is_wr;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/swmem_slot_timer.sv
module swmem_slot_timer
  import swmem_pkg::*;
#(
  parameter int unsigned T_LOW0   = 8125,
  parameter int unsigned T_LOW1   = 625,
  parameter int unsigned T_SLOT   = 8750,
  parameter int unsigned T_REC    = 625,
  parameter int unsigned T_SAMPLE = 1500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  slot_kind_t kind,
  output logic       line_low_o,
  output logic       sample_o,
  output logic       slot_end_o
);

  localparam int unsigned PERIOD = T_SLOT + T_REC;
  localparam int unsigned CNT_W  = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] LEN0 = CNT_W'(T_LOW0);
  localparam logic [CNT_W-1:0] LEN1 = CNT_W'(T_LOW1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] SMP  = CNT_W'(T_SAMPLE);

  logic             active;
  logic [CNT_W-1:0] cnt;
  slot_kind_t       kind_q;
  logic [CNT_W-1:0] low_len;
  logic             drive_c;

  assign low_len    = (kind_q == SLOT_W0) ? LEN0 : LEN1;
  assign drive_c    = active && (cnt < low_len);
  assign slot_end_o = active && (cnt == LAST);
  // The output register delays the pin by one cycle, so comparing against
  // T_SAMPLE lands the sample T_SAMPLE cycles after the pin falls.
  assign sample_o   = active && (kind_q == SLOT_RD) && (cnt == SMP);

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      cnt        <= '0;
      kind_q     <= SLOT_W0;
      line_low_o <= 1'b0;
    end else begin
      line_low_o <= drive_c;
      if (go) begin
        active <= 1'b1;
        cnt    <= '0;
        kind_q <= kind;
      end else if (slot_end_o) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (active) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/swmem_seq.sv
module swmem_seq
  import swmem_pkg::*;
#(
  parameter int unsigned DATA_BITS = 256,
  parameter logic [1:0]  SEL       = 2'b00,
  localparam int unsigned PRE_SLOTS = CMD_BITS + DATA_BITS,
  localparam int unsigned IDX_W     = $clog2(PRE_SLOTS),
  localparam int unsigned DIDX_W    = $clog2(DATA_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              op_wr_i,
  input  logic              slot_end_i,
  input  logic              wr_bit_i,
  output logic [DIDX_W-1:0] pick_idx_o,
  output logic [DIDX_W-1:0] cur_idx_o,
  output logic              accept_o,
  output logic              go_o,
  output slot_kind_t        kind_o,
  output logic              rd_phase_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam logic [IDX_W-1:0] PRE_LAST  = IDX_W'(PRE_SLOTS - 1);
  localparam logic [IDX_W-1:0] CMD_LAST  = IDX_W'(CMD_BITS - 1);
  localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(DATA_BITS - 1);

  seq_state_t       state, state_n;
  logic [IDX_W-1:0] idx, idx_n, idx_inc;
  logic             op_wr_q;
  slot_kind_t       data_kind;

  assign idx_inc    = idx + 1'b1;
  assign pick_idx_o = (state == ST_CMD) ? '0 : idx_inc[DIDX_W-1:0];
  assign cur_idx_o  = idx[DIDX_W-1:0];
  assign data_kind  = op_wr_q ? (wr_bit_i ? SLOT_W1 : SLOT_W0) : SLOT_RD;
  assign accept_o   = (state == ST_IDLE) && start_i;
  assign rd_phase_o = (state == ST_DATA) && !op_wr_q;
  assign busy_o     = (state != ST_IDLE);

  always_comb begin
    state_n = state;
    idx_n   = idx;
    go_o    = 1'b0;
    kind_o  = SLOT_W0;
    case (state)
      ST_IDLE: begin
        if (start_i) begin
          state_n = ST_PRE;
          idx_n   = '0;
          go_o    = 1'b1;
        end
      end
      ST_PRE: begin
        if (slot_end_i) begin
          go_o = 1'b1;
          if (idx == PRE_LAST) begin
            state_n = ST_CMD;
            idx_n   = '0;
            kind_o  = cmd_bit(3'd0, op_wr_q, SEL) ? SLOT_W1 : SLOT_W0;
          end else begin
            idx_n = idx_inc;
          end
        end
      end
      ST_CMD: begin
        if (slot_end_i) begin
          go_o = 1'b1;
          if (idx == CMD_LAST) begin
            state_n = ST_DATA;
            idx_n   = '0;
            kind_o  = data_kind;
          end else begin
            idx_n  = idx_inc;
            kind_o = cmd_bit(idx_inc[2:0], op_wr_q, SEL) ? SLOT_W1 : SLOT_W0;
          end
        end
      end
      ST_DATA: begin
        if (slot_end_i) begin
          if (idx == DATA_LAST) begin
            state_n = ST_DONE;
          end else begin
            go_o   = 1'b1;
            idx_n  = idx_inc;
            kind_o = data_kind;
          end
        end
      end
      ST_DONE: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      idx     <= '0;
      op_wr_q <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      state  <= state_n;
      idx    <= idx_n;
      done_o <= (state == ST_DATA) && slot_end_i && (idx == DATA_LAST);
      if (accept_o) op_wr_q <= op_wr_i;
    end
  end

endmodule

// File: rtl/swmem_data_path.sv
module swmem_data_path #(
  parameter int unsigned DATA_BITS = 256,
  localparam int unsigned DIDX_W   = $clog2(DATA_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_i,
  input  logic [DATA_BITS-1:0] wr_data_i,
  input  logic [DIDX_W-1:0]    pick_idx_i,
  output logic                 wr_bit_o,
  input  logic                 cap_i,
  input  logic [DIDX_W-1:0]    cap_idx_i,
  input  logic                 line_i,
  output logic [DATA_BITS-1:0] rd_data_o
);

  logic [DATA_BITS-1:0] wr_q;

  assign wr_bit_o = wr_q[pick_idx_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q      <= '0;
      rd_data_o <= '0;
    end else begin
      if (load_i) wr_q <= wr_data_i;
      if (cap_i)  rd_data_o[cap_idx_i] <= line_i;
    end
  end

endmodule

// File: rtl/swmem_host.sv
module swmem_host
  import swmem_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 125,
  parameter int unsigned T_LOW1     = 5 * CYC_PER_US,
  parameter int unsigned T_LOW0     = 65 * CYC_PER_US,
  parameter int unsigned T_SLOT     = 70 * CYC_PER_US,
  parameter int unsigned T_REC      = 5 * CYC_PER_US,
  parameter int unsigned T_SAMPLE   = 12 * CYC_PER_US,
  parameter int unsigned DATA_BITS  = 256,
  parameter logic [1:0]  SEL        = 2'b00
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 op_write,
  input  logic [DATA_BITS-1:0] wr_data,
  input  logic                 line_in,
  output logic                 line_oe,
  output logic                 busy,
  output logic                 done,
  output logic [DATA_BITS-1:0] rd_data
);

  localparam int unsigned DIDX_W = $clog2(DATA_BITS);

  logic              go, slot_end, smp, accept, rd_phase, wr_bit;
  slot_kind_t        kind;
  logic [DIDX_W-1:0] pick_idx, cur_idx;

  swmem_seq #(
    .DATA_BITS (DATA_BITS),
    .SEL       (SEL)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .op_wr_i    (op_write),
    .slot_end_i (slot_end),
    .wr_bit_i   (wr_bit),
    .pick_idx_o (pick_idx),
    .cur_idx_o  (cur_idx),
    .accept_o   (accept),
    .go_o       (go),
    .kind_o     (kind),
    .rd_phase_o (rd_phase),
    .busy_o     (busy),
    .done_o     (done)
  );

  swmem_slot_timer #(
    .T_LOW0   (T_LOW0),
    .T_LOW1   (T_LOW1),
    .T_SLOT   (T_SLOT),
    .T_REC    (T_REC),
    .T_SAMPLE (T_SAMPLE)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .kind       (kind),
    .line_low_o (line_oe),
    .sample_o   (smp),
    .slot_end_o (slot_end)
  );

  swmem_data_path #(
    .DATA_BITS (DATA_BITS)
  ) u_data (
    .clk        (clk),
    .rst        (rst),
    .load_i     (accept),
    .wr_data_i  (wr_data),
    .pick_idx_i (pick_idx),
    .wr_bit_o   (wr_bit),
    .cap_i      (smp && rd_phase),
    .cap_idx_i  (cur_idx),
    .line_i     (line_in),
    .rd_data_o  (rd_data)
  );

endmodule

// File: rtl/swmem_host_chk.sv
module swmem_host_chk #(
  parameter int unsigned T_LOW0    = 8125,
  parameter int unsigned DATA_BITS = 256
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 line_oe,
  input logic [DATA_BITS-1:0] rd_data
);

  int unsigned low_run;

  always_ff @(posedge clk) begin
    if (rst)          low_run <= 0;
    else if (line_oe) low_run <= low_run + 1;
    else              low_run <= 0;
  end

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !line_oe);

  assert_low_bound_R5: assert property (@(posedge clk) disable iff (rst)
    line_oe |-> (low_run < T_LOW0));

  assert_rd_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(rd_data));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_then_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  assert_busy_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !done) |=> busy);

  assert_start_accept_R10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

endmodule

bind swmem_host swmem_host_chk #(
  .T_LOW0    (T_LOW0),
  .DATA_BITS (DATA_BITS)
) u_swmem_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .line_oe (line_oe),
  .rd_data (rd_data)
);

// File: tb/test_swmem_host.sv
module test_swmem_host;

  localparam int unsigned TL1  = 2;
  localparam int unsigned TL0  = 8;
  localparam int unsigned TS   = 10;
  localparam int unsigned TR   = 2;
  localparam int unsigned TSMP = 4;
  localparam int unsigned NB   = 256;
  localparam int          PER  = TS + TR;
  localparam int          PRE  = 8 + NB;
  localparam int          TOT  = PRE + 8 + NB;
  localparam int          TH   = 5;   // width threshold between write-one and write-zero
  localparam int          HOLD = 6;   // device hold time for a read 0

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          op_write = 1'b0;
  logic [NB-1:0] wr_data = '0;
  logic          line_in;
  logic          line_oe;
  logic          busy;
  logic          done;
  logic [NB-1:0] rd_data;
  logic          dev_low = 1'b0;

  always #4 clk = ~clk;

  assign line_in = ~(line_oe | dev_low);

  swmem_host #(
    .T_LOW1 (TL1), .T_LOW0 (TL0), .T_SLOT (TS), .T_REC (TR),
    .T_SAMPLE (TSMP), .DATA_BITS (NB)
  ) i_swmem_host (
    .clk (clk), .rst (rst), .start (start), .op_write (op_write),
    .wr_data (wr_data), .line_in (line_in), .line_oe (line_oe),
    .busy (busy), .done (done), .rd_data (rd_data)
  );

  int nchecks = 0;
  int nfail   = 0;

  // behavioural device and line monitor
  logic [NB-1:0] dev_mem;
  int            dev_ptr    = 100;
  logic          dev_locked = 1'b0;
  int            dev_mode   = 0;     // 0 none, 1 write, 2 read
  logic [7:0]    dev_cmd    = '0;
  int            dev_hold   = 0;
  int            lowcnt     = 0;
  logic          prev_oe    = 1'b0;
  int            widths [0:599];
  int            npulse = 0, nfall = 0, bad_period = 0, done_cnt = 0;
  longint        cyc = 0, last_fall = 0;

  task automatic dev_slot(input logic b);
    if (dev_locked) begin
      if (b) begin
        dev_locked = 1'b0;
        dev_cmd    = 8'h01;
        dev_ptr    = 1;
        dev_mode   = 0;
      end
    end else if (dev_ptr < 8) begin
      dev_cmd[dev_ptr] = b;
      dev_ptr++;
      if (dev_ptr == 8) dev_mode = (dev_cmd[7:3] == 5'h1f) ? 1 : 2;
    end else begin
      if (dev_mode == 1) dev_mem[dev_ptr-8] = b;
      dev_ptr++;
      if (dev_ptr == PRE) dev_locked = 1'b1;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (done) done_cnt++;
    if (line_oe && !prev_oe) begin
      if (nfall > 0 && (cyc - last_fall) != PER) bad_period++;
      last_fall = cyc;
      nfall++;
      lowcnt = 0;
      if (dev_mode == 2 && !dev_locked && dev_ptr >= 8 && dev_ptr < PRE
          && !dev_mem[dev_ptr-8]) dev_hold = HOLD;
    end else if (dev_hold > 0) begin
      dev_hold--;
    end
    dev_low = (dev_hold > 0);
    if (line_oe) lowcnt++;
    if (!line_oe && prev_oe) begin
      if (npulse < 600) widths[npulse] = lowcnt;
      npulse++;
      dev_slot((lowcnt < TH) ? 1'b1 : 1'b0);
    end
    prev_oe = line_oe;
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [NB-1:0] act, input logic [NB-1:0] exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] rnd_vec();
    logic [NB-1:0] v;
    for (int i = 0; i < NB / 32; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  logic [NB-1:0] exp_mem;
  logic [NB-1:0] last_rd = '0;

  task automatic run_txn(input bit wr, input logic [NB-1:0] data, input bit inject);
    int n = 0;
    int bad = 0;
    logic [7:0]    cmd_seen, cmd_exp;
    logic [NB-1:0] seen;
    @(negedge clk);
    npulse = 0; nfall = 0; bad_period = 0; done_cnt = 0;
    start = 1'b1; op_write = wr; wr_data = data;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after accepted start", NB'(busy), NB'(1));
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      if (inject && n == 1000) begin
        start = 1'b1; op_write = !wr; wr_data = ~data;
      end else begin
        start = 1'b0;
      end
    end
    chk(n < 20000, "R8 done reached", NB'(n), NB'(20000));
    @(negedge clk);
    chk(busy == 1'b0, "R8 idle after done", NB'(busy), NB'(0));
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R8 done pulse count", NB'(done_cnt), NB'(1));
    chk(npulse == TOT, "R2 slot count", NB'(npulse), NB'(TOT));
    for (int i = 0; i < PRE; i++) if (widths[i] != TL0) bad++;
    chk(bad == 0, "R3 preamble write-zero slots", NB'(bad), NB'(0));
    for (int k = 0; k < 8; k++) cmd_seen[k] = (widths[PRE+k] == TL1);
    cmd_exp = {{5{wr}}, 2'b00, 1'b1};
    chk(cmd_seen == cmd_exp, "R4 command word", NB'(cmd_seen), NB'(cmd_exp));
    bad = 0;
    for (int i = 0; i < TOT; i++) if (widths[i] != TL0 && widths[i] != TL1) bad++;
    chk(bad == 0 && bad_period == 0, "R5 pulse widths and slot period",
        NB'(bad + bad_period), NB'(0));
    if (wr) begin
      for (int k = 0; k < NB; k++) seen[k] = (widths[PRE+8+k] == TL1);
      chk(seen == data, "R6 data slot encoding LSB first", seen, data);
      exp_mem = data;
      chk(dev_mem == exp_mem, "R6 device contents after write", dev_mem, exp_mem);
      chk(rd_data == last_rd, "R7 rd_data untouched by write", rd_data, last_rd);
    end else begin
      bad = 0;
      for (int k = 0; k < NB; k++) if (widths[PRE+8+k] != TL1) bad++;
      chk(bad == 0, "R7 read slots short", NB'(bad), NB'(0));
      chk(rd_data == exp_mem, "R7 read data", rd_data, exp_mem);
      last_rd = rd_data;
    end
    if (inject) begin
      repeat (300) @(negedge clk);
      chk(npulse == TOT, "R9 no slots after ignored start", NB'(npulse), NB'(TOT));
      chk(dev_mem == data, "R9 op and data kept from acceptance", dev_mem, data);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", '0, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end

  initial begin
    logic [NB-1:0] v;
    void'($urandom(32'd2024));
    dev_mem = rnd_vec();
    exp_mem = dev_mem;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && line_oe == 1'b0, "R1 outputs in reset",
        NB'({busy, done, line_oe}), '0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && line_oe == 1'b0 && rd_data == '0, "R1 idle after reset",
        rd_data, '0);
    run_txn(1'b0, '0, 1'b0);                 // initial contents
    run_txn(1'b1, '0, 1'b0);
    run_txn(1'b0, '0, 1'b0);
    run_txn(1'b1, '1, 1'b0);
    run_txn(1'b0, '0, 1'b0);
    run_txn(1'b1, {(NB/2){2'b01}}, 1'b0);
    run_txn(1'b0, '0, 1'b0);
    for (int t = 0; t < 3; t++) begin
      v = rnd_vec();
      run_txn(1'b1, v, 1'b0);
      run_txn(1'b0, '0, 1'b0);
    end
    v = rnd_vec();
    run_txn(1'b1, v, 1'b1);                  // start injected mid-transfer
    run_txn(1'b0, '0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end

endmodule